// File: doc/BRIEF.md
# Multi-input wakeup interrupt controller

This block watches eight asynchronous input pins and turns a chosen edge on any of them into a latched pending flag. Software configures it through a small register bus. Per pin, it chooses rising or falling sensitivity and decides whether the pin takes part at all. Pending flags remain set until software clears them.

Any pending flag whose pin is enabled drives three outputs. A wake request brings a halted core back to life. A halt-permit signal stays low so that the core cannot enter HALT while work is outstanding. An interrupt request is raised only when the block-level and global interrupt enables are both set. Each pin passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with the sample taken one cycle earlier.

Top module: `wkup_ctrl`

## Requirements
- R1: After reset, all three registers read 0, so every pin is disabled and rising-edge sensitive. After reset, wake_o and irq_o are 0 and halt_ok_o is 1.
- R2: An edge-select bit of 0 makes its pin respond to a 0-to-1 transition. A 1 makes it respond to a 1-to-0 transition. Bit i of each register belongs to pin_i[i].
- R3: A pin whose enable bit is 0 never sets its pending bit.
- R4: A pending bit stays set until a write to the pending register. That write clears each bit where wdata_i holds 0 and keeps each bit where wdata_i holds 1.
- R5: wake_o is 1 exactly when some pending bit has its enable bit set, whatever the interrupt enables are. Clearing the enable bit drops wake_o but leaves the pending bit readable as 1.
- R6: irq_o is 1 only when wake_o is 1, blk_ie_i is 1 and glb_ie_i is 1.
- R7: halt_ok_o is 0 whenever wake_o is 1, and 1 otherwise.
- R8: Suppose a qualifying pin transition is applied just after a rising clock edge. Then the pending bit and the status outputs show it after the third following rising edge, and not after the second.
- R9: If a write clears a pending bit in the same cycle that a new edge on that pin is latched, the bit ends up set.
- R10: The register map is address 0 = edge select, 1 = enable, 2 = pending. Reads are combinational from the addressed register. Address 3 reads 0, and writes to it change nothing.
- R11: Changing an edge-select bit does not by itself set the pending bit, even when the pin's current level matches the new polarity's end state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| pin_i | input | 8 | Asynchronous wakeup pins |
| blk_ie_i | input | 1 | Block interrupt enable |
| glb_ie_i | input | 1 | Global interrupt enable |
| wake_o | output | 1 | Wake request from HALT |
| irq_o | output | 1 | Interrupt request |
| halt_ok_o | output | 1 | HALT entry permitted |

## Verification
A pin change made right after a clock edge reaches the pending register at the third rising edge. The bench therefore samples pending, wake_o, irq_o and halt_ok_o 1 ns after that edge, and it also checks the edge before to pin the latency exactly. A register write takes effect at the edge on which we_i is sampled, and reads are combinational, so read-back happens 1 ns after the writing edge. The same-cycle clear-versus-edge case is lined up by holding the clearing write across exactly the third edge after the pin change.

// File: rtl/wkup_pkg.sv
`timescale 1ns/1ps
package wkup_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_SEL  = 2'd0,
    REG_EN   = 2'd1,
    REG_PEND = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/wkup_sync.sv
`timescale 1ns/1ps
module wkup_sync #(
  parameter int N_PINS = 8,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] fall_sel_i,
  output logic [N_PINS-1:0] edge_o
);
  logic [N_PINS-1:0] stg_q [STAGES];
  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] cur, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign cur = stg_q[STAGES-1];

  // previous sample is independent of polarity, so a select change cannot fake an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur;
  end

  assign rise   = cur & ~prev_q;
  assign fall   = ~cur & prev_q;
  assign edge_o = (rise & ~fall_sel_i) | (fall & fall_sel_i);

  p_no_edge_flat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == prev_q) |-> (edge_o == '0));
endmodule

// File: rtl/wkup_regs.sv
`timescale 1ns/1ps
module wkup_regs
  import wkup_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] wdata_i,
  input  logic [N_PINS-1:0] edge_i,
  output logic [N_PINS-1:0] rdata_o,
  output logic [N_PINS-1:0] sel_o,
  output logic [N_PINS-1:0] en_o,
  output logic [N_PINS-1:0] pend_o
);
  logic [N_PINS-1:0] sel_q, en_q, pend_q;
  logic [N_PINS-1:0] keep_mask, hit;
  logic              wr_sel, wr_en, wr_pend;

  assign wr_sel  = we_i && (addr_i == REG_SEL);
  assign wr_en   = we_i && (addr_i == REG_EN);
  assign wr_pend = we_i && (addr_i == REG_PEND);

  assign keep_mask = wr_pend ? wdata_i : '1;
  assign hit       = edge_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (wr_sel) sel_q <= wdata_i;
      if (wr_en)  en_q  <= wdata_i;
      pend_q <= (pend_q & keep_mask) | hit;  // new edge beats clear
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_SEL:  rdata_o = sel_q;
      REG_EN:   rdata_o = en_q;
      REG_PEND: rdata_o = pend_q;
      default:  rdata_o = '0;
    endcase
  end

  assign sel_o  = sel_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;

  p_no_set_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~$past(pend_q) & ~$past(en_q)) == '0);
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pend |=> ((~pend_q & $past(pend_q)) == '0));
  p_edge_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/wkup_ctrl.sv
`timescale 1ns/1ps
module wkup_ctrl
  import wkup_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              blk_ie_i,
  input  logic              glb_ie_i,
  output logic              wake_o,
  output logic              irq_o,
  output logic              halt_ok_o
);
  logic [N_PINS-1:0] sel, en, pend, edge_hit;

  wkup_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .fall_sel_i (sel),
    .edge_o     (edge_hit)
  );

  wkup_regs #(.N_PINS(N_PINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .edge_i  (edge_hit),
    .rdata_o (rdata_o),
    .sel_o   (sel),
    .en_o    (en),
    .pend_o  (pend)
  );

  assign wake_o    = |(pend & en);
  assign irq_o     = wake_o & blk_ie_i & glb_ie_i;
  assign halt_ok_o = ~wake_o;

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (wake_o && blk_ie_i && glb_ie_i));
  p_halt_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & en) != '0) |-> !halt_ok_o);
  p_wake_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (pend != '0));
endmodule

// File: tb/wkup_ctrl_test.sv
`timescale 1ns/1ps
module wkup_ctrl_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] addr = 0;
  logic       we = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [7:0] pins = 0;
  logic       blk_ie = 0, glb_ie = 0;
  logic       wake, irq, halt_ok;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  wkup_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .blk_ie_i(blk_ie), .glb_ie_i(glb_ie),
    .wake_o(wake), .irq_o(irq), .halt_ok_o(halt_ok)
  );

  // {sel, en, pins before, pins after, expected pending}
  localparam logic [39:0] VEC [7] = '{
    {8'h00, 8'hFF, 8'h00, 8'h0F, 8'h0F},
    {8'hFF, 8'hFF, 8'hFF, 8'hF0, 8'h0F},
    {8'h0F, 8'hFF, 8'hF0, 8'h0F, 8'h00},
    {8'h0F, 8'hFF, 8'h0F, 8'hF0, 8'hFF},
    {8'h00, 8'h55, 8'h00, 8'hFF, 8'h55},
    {8'hAA, 8'hF0, 8'hAA, 8'h55, 8'hF0},
    {8'h00, 8'hFF, 8'h3C, 8'h3C, 8'h00}
  };

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1;
    step();
    we = 0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1;
    step();
    // R1 reset state
    rd_chk("R1", 2'd0, 8'h00);
    rd_chk("R1", 2'd1, 8'h00);
    rd_chk("R1", 2'd2, 8'h00);
    chk("R1", {5'd0, wake, irq, halt_ok}, 8'h01);

    // R2/R3: table walk
    for (int v = 0; v < 7; v++) begin
      logic [7:0] s, e, p0, p1, x;
      {s, e, p0, p1, x} = VEC[v];
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);
      pins = p0;
      step(4);
      wr(2'd0, s);
      wr(2'd1, e);
      pins = p1;
      step(4);
      rd_chk(v == 4 ? "R3" : "R2", 2'd2, x);
      chk("R5", {7'd0, wake}, {7'd0, x != 0});
    end

    // R8 latency on pin 0
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
    pins = 8'h00; step(4);
    wr(2'd1, 8'h01);
    pins = 8'h01;
    step(2);
    rd_chk("R8", 2'd2, 8'h00);
    chk("R8", {7'd0, wake}, 8'h00);
    step();
    rd_chk("R8", 2'd2, 8'h01);
    chk("R8", {7'd0, wake}, 8'h01);

    // R5/R6/R7 gating
    blk_ie = 0; glb_ie = 0; #1;
    chk("R5", {6'd0, wake, irq}, 8'h02);
    chk("R7", {7'd0, halt_ok}, 8'h00);
    blk_ie = 1; glb_ie = 0; #1;
    chk("R6", {7'd0, irq}, 8'h00);
    blk_ie = 0; glb_ie = 1; #1;
    chk("R6", {7'd0, irq}, 8'h00);
    blk_ie = 1; glb_ie = 1; #1;
    chk("R6", {7'd0, irq}, 8'h01);

    // R4 keep on 1, clear on 0
    wr(2'd2, 8'hFF);
    rd_chk("R4", 2'd2, 8'h01);
    step(3);
    rd_chk("R4", 2'd2, 8'h01);

    // R5 disable keeps pending but drops wake
    wr(2'd1, 8'h00);
    rd_chk("R5", 2'd2, 8'h01);
    chk("R5", {5'd0, wake, irq, halt_ok}, 8'h01);
    wr(2'd1, 8'h01);
    chk("R7", {7'd0, halt_ok}, 8'h00);
    wr(2'd2, 8'h00);
    rd_chk("R4", 2'd2, 8'h00);
    chk("R7", {7'd0, halt_ok}, 8'h01);

    // R9 clear and edge in the same cycle; bit1 already pending
    wr(2'd1, 8'h03);
    pins = 8'h03; step(4);
    rd_chk("R9", 2'd2, 8'h02);
    pins = 8'h02;           // prepare falling then rising of pin0
    wr(2'd0, 8'h00);
    step(4);
    pins = 8'h03;           // rising on pin0 after this edge
    step(2);
    addr = 2'd2; wdata = 8'h00; we = 1;
    step();                 // third edge: latch and clear coincide
    we = 0;
    rd_chk("R9", 2'd2, 8'h01);

    // R11 select change on a settled high pin
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    step(4);
    rd_chk("R11", 2'd2, 8'h00);
    wr(2'd0, 8'h00);
    step(4);
    rd_chk("R11", 2'd2, 8'h00);

    // R10 unused address
    wr(2'd3, 8'hFF);
    rd_chk("R10", 2'd3, 8'h00);
    rd_chk("R10", 2'd0, 8'h00);
    rd_chk("R10", 2'd1, 8'h03);
    rd_chk("R10", 2'd2, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule